// File: doc/BRIEF.md
# Single-Density Track Format Sequencer

This block produces the byte stream that lays down one freshly formatted single-density soft-sector track. Software or a control FSM presents a track number and a data fill byte and pulses `start`. The sequencer then waits for the rising edge of the drive's index pulse. After that edge it hands bytes, one at a time, to a downstream FM encoder. Every byte comes with an 8-bit clock mask. A mask of all ones means normal clocking. A mask with zeros means clock bits are left out, which is how an address mark is made.

The stream follows a fixed order. It begins with an index mark and a leading gap. Then, for each of 26 sectors, it sends an ID mark, the ID body, two CRC slots, a short gap, a data mark, the fill data, two more CRC slots and an inter-sector gap. The last sector is followed by trailing fill, which lasts until the next index edge; at that edge the sequencer raises `done`. The sequencer does not compute CRC values. It flags each CRC slot with `out_crc`, and a CRC engine further down the path replaces those bytes.

The encoder sets the pace by pulsing `byte_tick` once for each byte it wants.

Top module: `track_fmt_seq`

## Requirements
- R1: While reset is asserted and directly after it, `out_valid`, `out_mark`, `out_crc` and `done` are 0 and `out_byte` is 8'h00.
- R2: A `start` pulse with `track` ≤ 76 arms the block. Until a rising edge is seen on `index_pulse`, no byte is emitted, whatever `byte_tick` does.
- R3: The first byte after the index edge is the index mark: data 8'hFC, clock 8'hD7, `out_mark`=1.
- R4: Every gap byte is data 8'h00 with clock 8'hFF, and both `out_mark` and `out_crc` are 0. The gap after the index mark is 32 bytes long.
- R5: Each ID field is sent as seven bytes in this order: ID mark (8'hFE, clock 8'hC7, `out_mark`=1), the track number, 8'h00, the sector number, 8'h00, and then two CRC slots. A CRC slot is data 8'h00, clock 8'hFF, `out_crc`=1. Sector numbers run 1 to 26 in ascending order.
- R6: Each ID field is followed by a 17-byte gap. After the gap comes the data mark (8'hFB, clock 8'hC7, `out_mark`=1), and then 128 bytes equal to the latched `fill` value with clock 8'hFF.
- R7: Each data field ends with two CRC slots. Sectors 1–25 are then followed by a 33-byte gap. Sector 26 leads straight into the trailing fill. The laid-out part of the track is therefore exactly 4888 bytes.
- R8: The trailing fill is gap bytes (8'h00/8'hFF), one per tick, sent without limit until an index rising edge arrives. That edge sets `done`=1. From then on no byte is emitted until the next accepted `start`.
- R9: A `start` with `track` > 76 is ignored. The block stays idle and emits nothing, even when an index edge follows.
- R10: Exactly one byte is emitted for each `byte_tick` taken while the block is running. `out_valid` is a one-cycle pulse in the cycle after the tick.
- R11: An index edge that arrives before the trailing fill has no effect on the layout sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arm request; latches `track` and `fill` |
| track | input | 7 | Track number written into every ID field |
| fill | input | 8 | Byte used for every data-field byte |
| index_pulse | input | 1 | Drive index signal, active high |
| byte_tick | input | 1 | Encoder request for the next byte |
| out_byte | output | 8 | Data byte |
| out_clk | output | 8 | Clock mask for the byte (1 = clock present) |
| out_valid | output | 1 | Byte strobe, one cycle |
| out_mark | output | 1 | Byte is an address mark |
| out_crc | output | 1 | Byte is a CRC slot to be replaced downstream |
| done | output | 1 | Track finished at the closing index edge |

## Verification
The bench instantiates the default parameters: 26 sectors, 128-byte data fields, and gaps of 32, 17 and 33 bytes. With these values every sector number from 1 to 26 appears, and the full 4888-byte layout runs through to the trailing fill. The bench formats tracks at both ends of the legal range (0 and 76) and tries the first illegal track (77). It paces the block with random tick gaps and injects a stray index edge in the middle of the track.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
  typedef enum logic [3:0] {
    FLD_IAM, FLD_GAP1, FLD_IDAM, FLD_IDB, FLD_IDCRC, FLD_GAP2,
    FLD_DAM, FLD_DATA, FLD_DCRC, FLD_GAP3, FLD_TAIL
  } fld_t;

  localparam logic [7:0] IAM_DATA = 8'hFC;
  localparam logic [7:0] IAM_CLK  = 8'hD7;
  localparam logic [7:0] IDM_DATA = 8'hFE;
  localparam logic [7:0] DM_DATA  = 8'hFB;
  localparam logic [7:0] MARK_CLK = 8'hC7;
  localparam logic [7:0] GAP_DATA = 8'h00;
  localparam logic [7:0] FULL_CLK = 8'hFF;
endpackage

// File: rtl/tfs_edge.sv
module tfs_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig_in;
  end

  assign rise = sig_in & ~sig_q;
endmodule

// File: rtl/tfs_walker.sv
module tfs_walker
  import tfs_pkg::*;
#(
  parameter int SECTORS  = 26,
  parameter int DATA_LEN = 128,
  parameter int GAP1     = 32,
  parameter int GAP2     = 17,
  parameter int GAP3     = 33,
  parameter int CW       = 8,
  parameter int SW       = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  output fld_t          fld,
  output logic [CW-1:0] pos,
  output logic [SW-1:0] sec
);
  function automatic int fld_len(fld_t f);
    case (f)
      FLD_GAP1:             return GAP1;
      FLD_GAP2:             return GAP2;
      FLD_GAP3:             return GAP3;
      FLD_DATA:             return DATA_LEN;
      FLD_IDB:              return 4;
      FLD_IDCRC, FLD_DCRC:  return 2;
      default:              return 1;
    endcase
  endfunction

  logic last_pos;
  assign last_pos = (pos == CW'(fld_len(fld) - 1));

  always_ff @(posedge clk) begin
    if (rst || load) begin
      fld <= FLD_IAM;
      pos <= '0;
      sec <= '0;
    end else if (step && fld != FLD_TAIL) begin
      if (!last_pos) begin
        pos <= pos + 1'b1;
      end else begin
        pos <= '0;
        case (fld)
          FLD_IAM:   fld <= FLD_GAP1;
          FLD_GAP1:  fld <= FLD_IDAM;
          FLD_IDAM:  fld <= FLD_IDB;
          FLD_IDB:   fld <= FLD_IDCRC;
          FLD_IDCRC: fld <= FLD_GAP2;
          FLD_GAP2:  fld <= FLD_DAM;
          FLD_DAM:   fld <= FLD_DATA;
          FLD_DATA:  fld <= FLD_DCRC;
          FLD_DCRC:  fld <= (sec == SW'(SECTORS - 1)) ? FLD_TAIL : FLD_GAP3;
          FLD_GAP3: begin
            fld <= FLD_IDAM;
            sec <= sec + 1'b1;
          end
          default:   fld <= FLD_TAIL;
        endcase
      end
    end
  end

  // R7
  sector_range_chk: assert property (@(posedge clk) disable iff (rst)
    sec < SW'(SECTORS));
endmodule

// File: rtl/tfs_bytegen.sv
module tfs_bytegen
  import tfs_pkg::*;
#(
  parameter int CW    = 8,
  parameter int SW    = 5,
  parameter int TRK_W = 7
) (
  input  fld_t             fld,
  input  logic [CW-1:0]    pos,
  input  logic [SW-1:0]    sec,
  input  logic [TRK_W-1:0] trk,
  input  logic [7:0]       fill,
  output logic [7:0]       byte_o,
  output logic [7:0]       clk_o,
  output logic             mark_o,
  output logic             crc_o
);
  always_comb begin
    byte_o = GAP_DATA;
    clk_o  = FULL_CLK;
    mark_o = 1'b0;
    crc_o  = 1'b0;
    case (fld)
      FLD_IAM: begin
        byte_o = IAM_DATA; clk_o = IAM_CLK; mark_o = 1'b1;
      end
      FLD_IDAM: begin
        byte_o = IDM_DATA; clk_o = MARK_CLK; mark_o = 1'b1;
      end
      FLD_DAM: begin
        byte_o = DM_DATA; clk_o = MARK_CLK; mark_o = 1'b1;
      end
      FLD_IDB: begin
        if (pos == CW'(0))      byte_o = 8'(trk);
        else if (pos == CW'(2)) byte_o = 8'(sec) + 8'd1;
      end
      FLD_DATA:            byte_o = fill;
      FLD_IDCRC, FLD_DCRC: crc_o  = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/track_fmt_seq.sv
module track_fmt_seq
  import tfs_pkg::*;
#(
  parameter int TRK_W     = 7,
  parameter int MAX_TRACK = 76,
  parameter int SECTORS   = 26,
  parameter int DATA_LEN  = 128,
  parameter int GAP1      = 32,
  parameter int GAP2      = 17,
  parameter int GAP3      = 33
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [TRK_W-1:0] track,
  input  logic [7:0]       fill,
  input  logic             index_pulse,
  input  logic             byte_tick,
  output logic [7:0]       out_byte,
  output logic [7:0]       out_clk,
  output logic             out_valid,
  output logic             out_mark,
  output logic             out_crc,
  output logic             done
);
  localparam int MAXL_A = (DATA_LEN > GAP3) ? DATA_LEN : GAP3;
  localparam int MAXL_B = (GAP1 > GAP2) ? GAP1 : GAP2;
  localparam int MAXL   = (MAXL_A > MAXL_B) ? MAXL_A : MAXL_B;
  localparam int CW     = $clog2(MAXL + 1);
  localparam int SW     = $clog2(SECTORS + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN, S_DONE} st_t;
  st_t st;

  logic [TRK_W-1:0] trk_q;
  logic [7:0]       fill_q;
  logic             idx_rise, accept, step, in_tail, close;
  fld_t             fld;
  logic [CW-1:0]    pos;
  logic [SW-1:0]    sec;
  logic [7:0]       g_byte, g_clk;
  logic             g_mark, g_crc;

  tfs_edge u_edge (.clk(clk), .rst(rst), .sig_in(index_pulse), .rise(idx_rise));

  assign accept  = start && (st == S_IDLE || st == S_DONE) &&
                   (track <= TRK_W'(MAX_TRACK));
  assign in_tail = (fld == FLD_TAIL);
  assign close   = (st == S_RUN) && in_tail && idx_rise;
  assign step    = (st == S_RUN) && byte_tick && !close;

  tfs_walker #(.SECTORS(SECTORS), .DATA_LEN(DATA_LEN), .GAP1(GAP1),
               .GAP2(GAP2), .GAP3(GAP3), .CW(CW), .SW(SW)) u_walk (
    .clk(clk), .rst(rst), .load(accept), .step(step),
    .fld(fld), .pos(pos), .sec(sec));

  tfs_bytegen #(.CW(CW), .SW(SW), .TRK_W(TRK_W)) u_gen (
    .fld(fld), .pos(pos), .sec(sec), .trk(trk_q), .fill(fill_q),
    .byte_o(g_byte), .clk_o(g_clk), .mark_o(g_mark), .crc_o(g_crc));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; trk_q <= '0; fill_q <= '0; done <= 1'b0;
    end else begin
      if (accept) begin
        st <= S_WAIT; trk_q <= track; fill_q <= fill; done <= 1'b0;
      end else if (st == S_WAIT && idx_rise) begin
        st <= S_RUN;
      end else if (close) begin
        st <= S_DONE; done <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_byte <= '0; out_clk <= '0; out_valid <= 1'b0;
      out_mark <= 1'b0; out_crc <= 1'b0;
    end else begin
      out_valid <= step;
      out_mark  <= step && g_mark;
      out_crc   <= step && g_crc;
      if (step) begin
        out_byte <= g_byte;
        out_clk  <= g_clk;
      end
    end
  end

  // R10
  mark_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_mark |-> out_valid);
  // R5
  crc_slot_chk: assert property (@(posedge clk) disable iff (rst)
    out_crc |-> (out_valid && !out_mark));
  // R8
  done_on_index_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(idx_rise) && $past(in_tail)));
  // R8
  quiet_when_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid);
  // R9
  bad_track_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && start && track > TRK_W'(MAX_TRACK)) |=> st == S_IDLE);
endmodule

// File: tb/track_fmt_seq_tb.sv
module track_fmt_seq_tb;
  localparam int LAYOUT = 4888;
  localparam int TAILN  = 6;

  logic clk = 1'b0;
  logic rst, start, index_pulse, byte_tick;
  logic [6:0] track;
  logic [7:0] fill, out_byte, out_clk;
  logic out_valid, out_mark, out_crc, done;
  int checks = 0, fails = 0, cycles = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  track_fmt_seq u_dut (.clk(clk), .rst(rst), .start(start), .track(track),
    .fill(fill), .index_pulse(index_pulse), .byte_tick(byte_tick),
    .out_byte(out_byte), .out_clk(out_clk), .out_valid(out_valid),
    .out_mark(out_mark), .out_crc(out_crc), .done(done));

  // returns {byte, clock, mark, crc}
  function automatic logic [17:0] expect_at(int k, logic [6:0] trk, logic [7:0] fb);
    int rem, s, o;
    if (k == 0) return {8'hFC, 8'hD7, 2'b10};
    if (k <= 32 || k >= LAYOUT) return {8'h00, 8'hFF, 2'b00};
    rem = k - 33; s = rem / 188; o = rem % 188;
    if (o == 0)   return {8'hFE, 8'hC7, 2'b10};
    if (o == 1)   return {1'b0, trk, 8'hFF, 2'b00};
    if (o == 3)   return {8'(s + 1), 8'hFF, 2'b00};
    if (o == 5 || o == 6 || o == 153 || o == 154) return {8'h00, 8'hFF, 2'b01};
    if (o == 24)  return {8'hFB, 8'hC7, 2'b10};
    if (o >= 25 && o <= 152) return {fb, 8'hFF, 2'b00};
    return {8'h00, 8'hFF, 2'b00};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(int k);
    int o;
    if (k == 0) return "R3";
    if (k <= 32) return "R4";
    if (k >= LAYOUT) return "R8";
    o = (k - 33) % 188;
    if (o <= 6) return "R5";
    if (o <= 152) return "R6";
    return "R7";
  endfunction

  task automatic run_track(logic [6:0] trk, logic [7:0] fb, bit stray);
    int k = 0;
    logic [17:0] e;
    logic prev_tick = 1'b0;
    @(negedge clk); start = 1'b1; track = trk; fill = fb;
    @(negedge clk); start = 1'b0; track = 7'h7F;
    for (int i = 0; i < 6; i++) begin
      byte_tick = 1'b1;
      @(negedge clk);
      chk(!out_valid, "R2", out_valid, 0);
    end
    byte_tick = 1'b0;
    index_pulse = 1'b1; @(negedge clk); index_pulse = 1'b0;
    while (k < LAYOUT + TAILN) begin
      @(negedge clk);
      index_pulse = 1'b0;
      if (out_valid !== prev_tick) chk(0, "R10", out_valid, prev_tick);
      if (out_valid) begin
        e = expect_at(k, trk, fb);
        chk({out_byte, out_clk, out_mark, out_crc} === e, req_of(k),
            {out_byte, out_clk, out_mark, out_crc}, e);
        k++;
      end
      if (stray && k == 2000 && !index_pulse) index_pulse = 1'b1; // R11
      byte_tick = (k < LAYOUT + TAILN) && ($urandom % 3 != 0);
      prev_tick = byte_tick;
    end
    byte_tick = 1'b0;
    @(negedge clk);
    chk(!done, "R8", done, 0);
    index_pulse = 1'b1; @(negedge clk); index_pulse = 1'b0;
    @(negedge clk);
    chk(done === 1'b1, "R8", done, 1);
    byte_tick = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!out_valid, "R8", out_valid, 0);
    end
    byte_tick = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; start = 0; index_pulse = 0; byte_tick = 0; track = 0; fill = 0;
    repeat (3) @(negedge clk);
    chk({out_valid, out_mark, out_crc, done} == 4'b0 && out_byte == 8'h00, "R1",
        {out_valid, out_mark, out_crc, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !done, "R1", {out_valid, done}, 0);
    run_track(7'd0, 8'hE5, 1'b0);
    run_track(7'd76, 8'($urandom), 1'b1);
    // R9: illegal track ignored, done from previous track remains
    @(negedge clk); start = 1'b1; track = 7'd77;
    @(negedge clk); start = 1'b0;
    index_pulse = 1'b1; byte_tick = 1'b1;
    @(negedge clk); index_pulse = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!out_valid && done, "R9", {out_valid, done}, 1);
    end
    byte_tick = 1'b0;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule